// File: doc/BRIEF.md
# Monitor Register Access Trap Arbiter

This block settles, in a single combinational step, what happens when software reads or writes a protected performance-monitor control register. It takes the current privilege level (0 to 3) together with the configuration of the levels above it. For each of levels 1, 2 and 3 it takes whether that level exists or is enabled and whether it runs in the legacy execution state. It also takes the user-access enable bits, the hypervisor trap controls, the fine-grained read and write trap bits and the secure-monitor trap controls. From these it produces exactly one action and an 8-bit syndrome code for the exception entry logic.

The decision is a strictly ordered list of checks, and the list depends on the privilege level. Level 3 is always allowed. Level 2 sees only the secure-monitor checks. Levels 0 and 1 also see the hypervisor checks. Level 0 additionally sees the user-enable check and the fine-grained traps. The first check that matches decides the outcome. When no check matches, the access is allowed. Register storage and exception entry lie outside this block.

Top module: `pmu_access_arbiter`

## Requirements
- R1: When `mon_present` is 0, the action is undefined-instruction at every privilege level.
- R2: With the feature present, an access at level 3 is allowed whatever the other controls are.
- R3: At levels 0 to 2, when level 3 is present in the modern state and both `mon_tpm` and `sdd_undef_prio` are 1, the action is undefined-instruction, ahead of every other check.
- R4: At level 0 with a modern level 1, a user-enable failure traps. The default build counts it as a failure only when all three `usr_en` bits are 0. A 2-bit build looks only at bits [1:0]. The trap goes to level 1. It goes to level 2 in modern style instead when level 2 is enabled, is modern and has `hyp_tge` set. Both traps carry syndrome 0x03.
- R5: At level 0 with a legacy level 1, `usr_en[1:0]` equal to 0 leads to one of three outcomes. A modern level 2 with `hyp_tge` gives a modern level-2 trap with syndrome 0x03. A legacy level 2 with `hyp_tge` gives a legacy level-2 trap with syndrome 0x00. Otherwise the access is undefined.
- R6: `hyp_t9` traps to level 2 at level 1, and at level 0 outside host mode, when level 2 is enabled. The trap is in legacy style when level 2 is legacy, otherwise in modern style, with syndrome 0x03.
- R7: At level 0 outside host mode, with level 2 enabled and level 1 modern, a fine-grained trap causes a modern level-2 trap with syndrome 0x03. A read uses `fgt_rd_trap` and a write uses `fgt_wr_trap`. The check applies only when level 3 is absent or `l3_fgt_en` is 1. It never applies at level 1.
- R8: `hyp_tpm` traps to level 2 at levels 0 and 1 when level 2 is enabled, in the style of level 2, with syndrome 0x03. At level 2 it has no effect.
- R9: At levels 0 to 2, a modern level 3 with `mon_tpm` set traps to level 3 with syndrome 0x03, or is undefined when `sdd_undef` is 1. This check comes last.
- R10: The order is: the early undefined case, then user-enable, then T9, then fine-grained, then hypervisor TPM, then secure-monitor TPM.
- R11: `act_onehot` has exactly one bit set. The bits are [0] allow, [1] undefined, [2] trap to level 1, [3] trap to level 2 in modern style, [4] trap to level 2 in legacy style, [5] trap to level 3. `syndrome` is 0x00 for allow and undefined.
- R12: When no check matches, the access is allowed with syndrome 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_present | input | 1 | Monitor feature and legacy-state register access exist |
| cur_lvl | input | 2 | Current privilege level |
| is_write | input | 1 | 1 for a write, 0 for a read |
| l1_legacy | input | 1 | Level 1 runs in the legacy state |
| l2_enabled | input | 1 | Level 2 is enabled |
| l2_legacy | input | 1 | Level 2 runs in the legacy state |
| l3_present | input | 1 | Level 3 exists |
| l3_legacy | input | 1 | Level 3 runs in the legacy state |
| host_mode | input | 1 | Level 0 runs under a host-mode level 2 |
| usr_en | input | 3 | User-access enable bits |
| hyp_tge | input | 1 | Level-2 trap-general bit |
| hyp_t9 | input | 1 | Level-2 coprocessor group trap |
| hyp_tpm | input | 1 | Level-2 monitor register trap |
| fgt_rd_trap | input | 1 | Fine-grained read trap |
| fgt_wr_trap | input | 1 | Fine-grained write trap |
| l3_fgt_en | input | 1 | Level 3 permits fine-grained traps |
| mon_tpm | input | 1 | Level-3 monitor register trap |
| sdd_undef_prio | input | 1 | Secure-disable undefined takes early priority |
| sdd_undef | input | 1 | Secure-disable turns level-3 traps into undefined |
| act_onehot | output | 6 | One-hot action |
| syndrome | output | 8 | Syndrome code for the trap |

## Verification
The hardest outcome to reach is the legacy level-2 trap with syndrome 0x00. It needs a legacy level 1, a legacy enabled level 2, the trap-general bit set and the user bits cleared, all at level 0 with no early undefined case. The directed task sets that exact mix and then turns each ingredient off in turn. Priority is checked by stacking several trap causes at once and removing the winner step by step. The stacked cases use `l2_legacy` so that the fine-grained trap (always modern style) can be told apart from the hypervisor TPM trap (legacy style). A random sweep against a behavioural model then covers mixed combinations.

// File: rtl/pmacc_pkg.sv
`timescale 1ns/1ps
package pmacc_pkg;
   localparam int ACT_N  = 6;
   localparam int SYND_W = 8;
   localparam logic [SYND_W-1:0] SYN_TRAP = 8'h03;
   localparam logic [SYND_W-1:0] SYN_TGE_LEG = 8'h00;
   localparam logic [SYND_W-1:0] SYN_NONE = 8'h00;

   typedef enum logic [2:0] {
      ACT_ALLOW       = 3'd0,
      ACT_UNDEF       = 3'd1,
      ACT_TRAP_L1     = 3'd2,
      ACT_TRAP_L2     = 3'd3,
      ACT_TRAP_L2_LEG = 3'd4,
      ACT_TRAP_L3     = 3'd5
   } act_e;

   typedef struct packed {
      logic              hit;
      act_e              act;
      logic [SYND_W-1:0] synd;
   } verdict_t;
endpackage

// File: rtl/pmacc_user_gate.sv
`timescale 1ns/1ps
module pmacc_user_gate
   import pmacc_pkg::*;
#(
   parameter int UEN_BITS = 3
) (
   input  logic       at_user,
   input  logic       l1_legacy,
   input  logic [2:0] usr_en,
   input  logic       l2_modern,
   input  logic       l2_leg,
   input  logic       tge,
   output verdict_t   v_user
);
   logic modern_fail;
   logic legacy_fail;

   generate
      if (UEN_BITS == 3) begin : g_uen3
         assign modern_fail = (usr_en == 3'b000);
      end else begin : g_uen2
         assign modern_fail = (usr_en[1:0] == 2'b00);
      end
   endgenerate

   assign legacy_fail = (usr_en[1:0] == 2'b00);

   always_comb begin
      v_user = '0;
      if (at_user && !l1_legacy && modern_fail) begin
         v_user.hit  = 1'b1;
         v_user.synd = SYN_TRAP;
         v_user.act  = (l2_modern && tge) ? ACT_TRAP_L2 : ACT_TRAP_L1;
      end else if (at_user && l1_legacy && legacy_fail) begin
         v_user.hit = 1'b1;
         if (l2_modern && tge) begin
            v_user.act  = ACT_TRAP_L2;
            v_user.synd = SYN_TRAP;
         end else if (l2_leg && tge) begin
            v_user.act  = ACT_TRAP_L2_LEG;
            v_user.synd = SYN_TGE_LEG;
         end else begin
            v_user.act  = ACT_UNDEF;
            v_user.synd = SYN_NONE;
         end
      end
   end

   // R4: a user gate hit never lands on level 3 or on allow
   always_comb begin
      if (v_user.hit)
         p_user_target_r4: assert (v_user.act != ACT_ALLOW && v_user.act != ACT_TRAP_L3);
   end
endmodule

// File: rtl/pmacc_hyp_gate.sv
`timescale 1ns/1ps
module pmacc_hyp_gate
   import pmacc_pkg::*;
#(
   parameter bit HAS_FGT = 1'b1
) (
   input  logic [1:0] cur_lvl,
   input  logic       host_mode,
   input  logic       l2_enabled,
   input  logic       l2_legacy,
   input  logic       l1_legacy,
   input  logic       l3_present,
   input  logic       l3_fgt_en,
   input  logic       is_write,
   input  logic       hyp_t9,
   input  logic       hyp_tpm,
   input  logic       fgt_rd_trap,
   input  logic       fgt_wr_trap,
   output verdict_t   v_t9,
   output verdict_t   v_fgt,
   output verdict_t   v_tpm
);
   logic guest_user;
   logic below_hyp;
   act_e l2_style;

   assign guest_user = (cur_lvl == 2'd0) && !host_mode;
   assign below_hyp  = (cur_lvl == 2'd0) || (cur_lvl == 2'd1);
   assign l2_style   = l2_legacy ? ACT_TRAP_L2_LEG : ACT_TRAP_L2;

   always_comb begin
      v_t9 = '0;
      if (l2_enabled && hyp_t9 && ((cur_lvl == 2'd1) || guest_user)) begin
         v_t9.hit  = 1'b1;
         v_t9.act  = l2_style;
         v_t9.synd = SYN_TRAP;
      end
   end

   generate
      if (HAS_FGT) begin : g_fgt
         logic dir_bit;
         logic fgt_allowed;
         assign dir_bit     = is_write ? fgt_wr_trap : fgt_rd_trap;
         assign fgt_allowed = !l3_present || l3_fgt_en;
         always_comb begin
            v_fgt = '0;
            if (guest_user && l2_enabled && !l1_legacy && fgt_allowed && dir_bit) begin
               v_fgt.hit  = 1'b1;
               v_fgt.act  = ACT_TRAP_L2;
               v_fgt.synd = SYN_TRAP;
            end
         end
      end else begin : g_no_fgt
         assign v_fgt = '0;
      end
   endgenerate

   always_comb begin
      v_tpm = '0;
      if (l2_enabled && hyp_tpm && below_hyp) begin
         v_tpm.hit  = 1'b1;
         v_tpm.act  = l2_style;
         v_tpm.synd = SYN_TRAP;
      end
   end

   // R8: no hypervisor check ever fires at level 2 or 3
   always_comb begin
      if (!below_hyp)
         p_hyp_quiet_r8: assert (!v_t9.hit && !v_fgt.hit && !v_tpm.hit);
   end
endmodule

// File: rtl/pmacc_mon_gate.sv
`timescale 1ns/1ps
module pmacc_mon_gate
   import pmacc_pkg::*;
(
   input  logic [1:0] cur_lvl,
   input  logic       l3_present,
   input  logic       l3_legacy,
   input  logic       mon_tpm,
   input  logic       sdd_undef_prio,
   input  logic       sdd_undef,
   output verdict_t   v_early,
   output verdict_t   v_late
);
   logic armed;

   assign armed = (cur_lvl != 2'd3) && l3_present && !l3_legacy && mon_tpm;

   always_comb begin
      v_early = '0;
      if (armed && sdd_undef_prio) begin
         v_early.hit = 1'b1;
         v_early.act = ACT_UNDEF;
      end
   end

   always_comb begin
      v_late = '0;
      if (armed) begin
         v_late.hit  = 1'b1;
         v_late.act  = sdd_undef ? ACT_UNDEF : ACT_TRAP_L3;
         v_late.synd = sdd_undef ? SYN_NONE : SYN_TRAP;
      end
   end

   // R3: an early hit always implies the late check would also match
   always_comb begin
      if (v_early.hit)
         p_early_implies_late_r3: assert (v_late.hit);
   end
endmodule

// File: rtl/pmacc_prio_pick.sv
`timescale 1ns/1ps
module pmacc_prio_pick
   import pmacc_pkg::*;
#(
   parameter int N = 8
) (
   input  verdict_t [N-1:0]    vin,
   output logic [ACT_N-1:0]    act_onehot,
   output logic [SYND_W-1:0]   syndrome
);
   act_e chosen_act;

   always_comb begin
      chosen_act = ACT_ALLOW;
      syndrome   = SYN_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (vin[i].hit) begin
            chosen_act = vin[i].act;
            syndrome   = vin[i].synd;
         end
      end
      for (int k = 0; k < ACT_N; k++)
         act_onehot[k] = (int'(chosen_act) == k);
   end

   // R11: exactly one action bit
   always_comb begin
      p_onehot_r11: assert ($countones(act_onehot) == 1);
   end
endmodule

// File: rtl/pmu_access_arbiter.sv
`timescale 1ns/1ps
module pmu_access_arbiter
   import pmacc_pkg::*;
#(
   parameter int UEN_BITS = 3,
   parameter bit HAS_FGT  = 1'b1
) (
   input  logic        mon_present,
   input  logic [1:0]  cur_lvl,
   input  logic        is_write,
   input  logic        l1_legacy,
   input  logic        l2_enabled,
   input  logic        l2_legacy,
   input  logic        l3_present,
   input  logic        l3_legacy,
   input  logic        host_mode,
   input  logic [2:0]  usr_en,
   input  logic        hyp_tge,
   input  logic        hyp_t9,
   input  logic        hyp_tpm,
   input  logic        fgt_rd_trap,
   input  logic        fgt_wr_trap,
   input  logic        l3_fgt_en,
   input  logic        mon_tpm,
   input  logic        sdd_undef_prio,
   input  logic        sdd_undef,
   output logic [5:0]  act_onehot,
   output logic [7:0]  syndrome
);
   // stage order is the priority order, index 0 first
   localparam int S_ABSENT = 0;
   localparam int S_TOP    = 1;
   localparam int S_EARLY  = 2;
   localparam int S_USER   = 3;
   localparam int S_T9     = 4;
   localparam int S_FGT    = 5;
   localparam int S_HTPM   = 6;
   localparam int S_MTPM   = 7;
   localparam int N_STAGES = S_MTPM + 1;

   generate
      if (UEN_BITS != 2 && UEN_BITS != 3) begin : g_bad_uen
         $error("UEN_BITS must be 2 or 3");
      end
      if (ACT_N != 6 || SYND_W != 8) begin : g_bad_pkg
         $error("output widths do not match the package");
      end
   endgenerate

   verdict_t [N_STAGES-1:0] stage;
   logic l2_modern;
   logic l2_leg;

   assign l2_modern = l2_enabled && !l2_legacy;
   assign l2_leg    = l2_enabled && l2_legacy;

   always_comb begin
      stage[S_ABSENT]      = '0;
      stage[S_ABSENT].hit  = !mon_present;
      stage[S_ABSENT].act  = ACT_UNDEF;
      stage[S_TOP]         = '0;
      stage[S_TOP].hit     = (cur_lvl == 2'd3);
      stage[S_TOP].act     = ACT_ALLOW;
   end

   pmacc_mon_gate u_mon (
      .cur_lvl        (cur_lvl),
      .l3_present     (l3_present),
      .l3_legacy      (l3_legacy),
      .mon_tpm        (mon_tpm),
      .sdd_undef_prio (sdd_undef_prio),
      .sdd_undef      (sdd_undef),
      .v_early        (stage[S_EARLY]),
      .v_late         (stage[S_MTPM])
   );

   pmacc_user_gate #(.UEN_BITS(UEN_BITS)) u_user (
      .at_user   (cur_lvl == 2'd0),
      .l1_legacy (l1_legacy),
      .usr_en    (usr_en),
      .l2_modern (l2_modern),
      .l2_leg    (l2_leg),
      .tge       (hyp_tge),
      .v_user    (stage[S_USER])
   );

   pmacc_hyp_gate #(.HAS_FGT(HAS_FGT)) u_hyp (
      .cur_lvl     (cur_lvl),
      .host_mode   (host_mode),
      .l2_enabled  (l2_enabled),
      .l2_legacy   (l2_legacy),
      .l1_legacy   (l1_legacy),
      .l3_present  (l3_present),
      .l3_fgt_en   (l3_fgt_en),
      .is_write    (is_write),
      .hyp_t9      (hyp_t9),
      .hyp_tpm     (hyp_tpm),
      .fgt_rd_trap (fgt_rd_trap),
      .fgt_wr_trap (fgt_wr_trap),
      .v_t9        (stage[S_T9]),
      .v_fgt       (stage[S_FGT]),
      .v_tpm       (stage[S_HTPM])
   );

   pmacc_prio_pick #(.N(N_STAGES)) u_pick (
      .vin        (stage),
      .act_onehot (act_onehot),
      .syndrome   (syndrome)
   );

   // port-level checks across the gates and the picker
   always_comb begin
      if (!mon_present)
         p_absent_undef_r1: assert (act_onehot == 6'b000010);
      if (mon_present && cur_lvl == 2'd3)
         p_top_allow_r2: assert (act_onehot == 6'b000001);
      if (mon_present && cur_lvl != 2'd3 && l3_present && !l3_legacy && mon_tpm && sdd_undef_prio)
         p_early_undef_r3: assert (act_onehot == 6'b000010);
      if (mon_present && cur_lvl == 2'd2)
         p_no_l2_from_l2_r8: assert (act_onehot[4:2] == 3'b000);
      if (act_onehot[0] || act_onehot[1])
         p_quiet_syndrome_r11: assert (syndrome == 8'h00);
   end
endmodule

// File: tb/tb_pmu_access_arbiter.sv
`timescale 1ns/1ps
module tb_pmu_access_arbiter;
   localparam logic [5:0] A_ALLOW = 6'b000001;
   localparam logic [5:0] A_UNDEF = 6'b000010;
   localparam logic [5:0] A_L1    = 6'b000100;
   localparam logic [5:0] A_L2    = 6'b001000;
   localparam logic [5:0] A_L2L   = 6'b010000;
   localparam logic [5:0] A_L3    = 6'b100000;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       mon_present, is_write, l1_legacy, l2_enabled, l2_legacy;
   logic       l3_present, l3_legacy, host_mode, hyp_tge, hyp_t9, hyp_tpm;
   logic       fgt_rd_trap, fgt_wr_trap, l3_fgt_en, mon_tpm, sdd_undef_prio, sdd_undef;
   logic [1:0] cur_lvl;
   logic [2:0] usr_en;
   logic [5:0] act_onehot;
   logic [7:0] syndrome;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   pmu_access_arbiter dut (
      .mon_present(mon_present), .cur_lvl(cur_lvl), .is_write(is_write),
      .l1_legacy(l1_legacy), .l2_enabled(l2_enabled), .l2_legacy(l2_legacy),
      .l3_present(l3_present), .l3_legacy(l3_legacy), .host_mode(host_mode),
      .usr_en(usr_en), .hyp_tge(hyp_tge), .hyp_t9(hyp_t9), .hyp_tpm(hyp_tpm),
      .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap), .l3_fgt_en(l3_fgt_en),
      .mon_tpm(mon_tpm), .sdd_undef_prio(sdd_undef_prio), .sdd_undef(sdd_undef),
      .act_onehot(act_onehot), .syndrome(syndrome)
   );

   task automatic baseline();
      mon_present = 1; cur_lvl = 0; is_write = 0; l1_legacy = 0;
      l2_enabled = 1; l2_legacy = 0; l3_present = 1; l3_legacy = 0;
      host_mode = 0; usr_en = 3'b111; hyp_tge = 0; hyp_t9 = 0; hyp_tpm = 0;
      fgt_rd_trap = 0; fgt_wr_trap = 0; l3_fgt_en = 1; mon_tpm = 0;
      sdd_undef_prio = 0; sdd_undef = 0;
   endtask

   task automatic check(string req, logic [5:0] exp_act, logic [7:0] exp_syn);
      @(negedge clk);
      n_checks++;
      if (act_onehot !== exp_act || syndrome !== exp_syn) begin
         n_fail++;
         $display("FAIL %s: act=%b syn=%h expected act=%b syn=%h",
                  req, act_onehot, syndrome, exp_act, exp_syn);
      end
      @(posedge clk);
   endtask

   // behavioural priority model for the sweep
   function automatic logic [13:0] model();
      logic l2m, l2l, l3m, mfail, lfail, guest, fdir;
      l2m = l2_enabled && !l2_legacy;
      l2l = l2_enabled && l2_legacy;
      l3m = l3_present && !l3_legacy;
      mfail = (usr_en == 3'b000);
      lfail = (usr_en[1:0] == 2'b00);
      guest = (cur_lvl == 0) && !host_mode;
      fdir  = is_write ? fgt_wr_trap : fgt_rd_trap;
      if (!mon_present) return {A_UNDEF, 8'h00};
      if (cur_lvl == 3) return {A_ALLOW, 8'h00};
      if (l3m && mon_tpm && sdd_undef_prio) return {A_UNDEF, 8'h00};
      if (cur_lvl == 0 && !l1_legacy && mfail)
         return {(l2m && hyp_tge) ? A_L2 : A_L1, 8'h03};
      if (cur_lvl == 0 && l1_legacy && lfail) begin
         if (l2m && hyp_tge) return {A_L2, 8'h03};
         if (l2l && hyp_tge) return {A_L2L, 8'h00};
         return {A_UNDEF, 8'h00};
      end
      if (cur_lvl != 2 && l2_enabled && hyp_t9 && (cur_lvl == 1 || guest))
         return {l2_legacy ? A_L2L : A_L2, 8'h03};
      if (guest && l2_enabled && !l1_legacy && (!l3_present || l3_fgt_en) && fdir)
         return {A_L2, 8'h03};
      if (cur_lvl != 2 && l2_enabled && hyp_tpm)
         return {l2_legacy ? A_L2L : A_L2, 8'h03};
      if (l3m && mon_tpm) return sdd_undef ? {A_UNDEF, 8'h00} : {A_L3, 8'h03};
      return {A_ALLOW, 8'h00};
   endfunction

   task automatic t_idle();
      baseline(); check("R12 idle allow", A_ALLOW, 8'h00);
      cur_lvl = 1; check("R12 idle allow lvl1", A_ALLOW, 8'h00);
   endtask

   task automatic t_absent();
      for (int l = 0; l < 4; l++) begin
         baseline(); mon_present = 0; cur_lvl = 2'(l);
         check("R1 absent undef", A_UNDEF, 8'h00);
      end
   endtask

   task automatic t_top();
      baseline(); cur_lvl = 3; usr_en = 0; hyp_t9 = 1; hyp_tpm = 1;
      mon_tpm = 1; sdd_undef_prio = 1; fgt_rd_trap = 1;
      check("R2 level3 allow", A_ALLOW, 8'h00);
   endtask

   task automatic t_early();
      for (int l = 0; l < 3; l++) begin
         baseline(); cur_lvl = 2'(l); mon_tpm = 1; sdd_undef_prio = 1;
         usr_en = 0; hyp_t9 = 1;
         check("R3 early undef", A_UNDEF, 8'h00);
      end
      baseline(); mon_tpm = 1; sdd_undef_prio = 1; l3_legacy = 1;
      check("R3 legacy level3 no early", A_ALLOW, 8'h00);
   endtask

   task automatic t_user_modern();
      baseline(); usr_en = 3'b000; check("R4 trap l1", A_L1, 8'h03);
      usr_en = 3'b100; check("R4 third bit enables", A_ALLOW, 8'h00);
      usr_en = 3'b000; hyp_tge = 1; check("R4 tge to l2", A_L2, 8'h03);
      cur_lvl = 1; check("R4 ignored at lvl1", A_ALLOW, 8'h00);
   endtask

   task automatic t_user_legacy();
      baseline(); l1_legacy = 1; usr_en = 3'b100; hyp_tge = 1;
      check("R5 modern l2 tge", A_L2, 8'h03);
      l2_legacy = 1; check("R5 legacy l2 tge syn00", A_L2L, 8'h00);
      hyp_tge = 0; check("R5 undef", A_UNDEF, 8'h00);
      usr_en = 3'b001; check("R5 enabled allow", A_ALLOW, 8'h00);
   endtask

   task automatic t_t9();
      baseline(); hyp_t9 = 1; check("R6 t9 lvl0", A_L2, 8'h03);
      host_mode = 1; check("R6 t9 host ignored", A_ALLOW, 8'h00);
      host_mode = 0; cur_lvl = 1; l2_legacy = 1; check("R6 t9 legacy lvl1", A_L2L, 8'h03);
      l2_enabled = 0; check("R6 t9 l2 off", A_ALLOW, 8'h00);
   endtask

   task automatic t_fgt();
      baseline(); fgt_rd_trap = 1; check("R7 read trap", A_L2, 8'h03);
      is_write = 1; check("R7 write ignores rd bit", A_ALLOW, 8'h00);
      fgt_wr_trap = 1; check("R7 write trap", A_L2, 8'h03);
      l3_fgt_en = 0; check("R7 l3 disables fgt", A_ALLOW, 8'h00);
      l3_present = 0; check("R7 no l3 fgt on", A_L2, 8'h03);
      cur_lvl = 1; check("R7 lvl1 ignored", A_ALLOW, 8'h00);
      cur_lvl = 0; host_mode = 1; check("R7 host ignored", A_ALLOW, 8'h00);
   endtask

   task automatic t_hyp_tpm();
      baseline(); cur_lvl = 1; hyp_tpm = 1; check("R8 tpm lvl1", A_L2, 8'h03);
      cur_lvl = 2; check("R8 tpm lvl2 ignored", A_ALLOW, 8'h00);
      cur_lvl = 0; l2_legacy = 1; check("R8 tpm legacy", A_L2L, 8'h03);
   endtask

   task automatic t_mon_tpm();
      baseline(); cur_lvl = 2; mon_tpm = 1; check("R9 trap l3", A_L3, 8'h03);
      sdd_undef = 1; check("R9 sdd undef", A_UNDEF, 8'h00);
      sdd_undef = 0; l3_legacy = 1; check("R9 legacy l3 ignored", A_ALLOW, 8'h00);
   endtask

   task automatic t_priority();
      baseline(); usr_en = 0; hyp_t9 = 1; hyp_tpm = 1; mon_tpm = 1;
      check("R10 user before t9", A_L1, 8'h03);
      usr_en = 3'b111; l2_legacy = 1; fgt_rd_trap = 1;
      check("R10 t9 before fgt", A_L2L, 8'h03);
      hyp_t9 = 0; check("R10 fgt before tpm", A_L2, 8'h03);
      fgt_rd_trap = 0; check("R10 tpm before mon", A_L2L, 8'h03);
      hyp_tpm = 0; check("R10 mon last", A_L3, 8'h03);
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 3000; i++) begin
         logic [13:0] exp;
         {mon_present, is_write, l1_legacy, l2_enabled, l2_legacy, l3_present,
          l3_legacy, host_mode, hyp_tge, hyp_t9, hyp_tpm, fgt_rd_trap,
          fgt_wr_trap, l3_fgt_en, mon_tpm, sdd_undef_prio, sdd_undef} = 17'($urandom);
         mon_present = ($urandom % 8) != 0;
         sdd_undef_prio = ($urandom % 4) == 0;
         cur_lvl = 2'($urandom);
         usr_en = 3'($urandom);
         exp = model();
         @(negedge clk);
         n_checks++;
         if ($countones(act_onehot) != 1) begin
            n_fail++;
            $display("FAIL R11 onehot: act=%b expected one bit", act_onehot);
         end
         @(posedge clk);
         check("R10 sweep vs model", exp[13:8], exp[7:0]);
      end
   endtask

   initial begin
      baseline();
      repeat (2) @(posedge clk);
      t_idle(); t_absent(); t_top(); t_early(); t_user_modern();
      t_user_legacy(); t_t9(); t_fgt(); t_hyp_tpm(); t_mon_tpm();
      t_priority(); t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule